// File: doc/BRIEF.md
# Mode-Configurable CIC Decimator

This block is the first decimation stage of a multistandard receiver. It takes a stream of signed samples and lowers the rate with a cascade of integrators running at the input rate, followed by a downsampler and a cascade of first-order differencers (combs) running at the output rate. The structure has no multipliers.

A two-bit mode selects one of three configurations: a rate reduction of 64 with five stages, 32 with five stages, or 16 with six stages. The internal accumulators carry enough guard bits for the largest gain among the modes. Each mode applies its own fixed right shift to the final comb value, so a constant input comes out at the same value in every mode. In five-stage modes the sixth integrator and the sixth comb are bypassed, and their registers stay at zero.

A small controller has two states. CLEAR is entered on reset or on a restart. It wipes all filter and counter state and latches the mode. On the next edge it moves to RUN, unless restart is still high. RUN accepts samples and moves back to CLEAR whenever restart is asserted. A new mode value takes effect only after this restart sequence.

Top module: `cic_mode_decim`

## Requirements
- R1: After reset or after a restart pulse, `out_valid` is low. The controller spends one cycle in CLEAR, during which samples are ignored. All integrator, comb and counter state is zero when RUN begins.
- R2: Mode encoding, read when leaving CLEAR: 0 gives a ratio of 64 with 5 stages, 1 gives 32 with 5 stages, 2 gives 16 with 6 stages, and 3 behaves exactly as 0.
- R3: A constant input x, held long enough to fill the filter, produces outputs equal to x exactly, for positive and negative x, in every mode.
- R4: Output k, counted from 0 after a restart, equals floor(S / 2^(N*log2 R)), where S is the input convolved with a length-R boxcar taken N times, evaluated at input index k*R + R - 1. The result is truncated to the output width.
- R5: Changing `mode` while in RUN has no effect on the ratio, the stage count or the output scaling until the next restart.
- R6: `out_valid` pulses for exactly one cycle, on the cycle after every R-th accepted sample. Cycles with `in_valid` low do not advance the count.
- R7: A sample presented in the same cycle as `restart` is discarded and does not contribute to any later output.
- R8: In five-stage modes, the sixth integrator and sixth comb registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Configuration select, latched when leaving CLEAR |
| restart | input | 1 | Synchronous restart; clears state and reloads mode |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe at the decimated rate |
| out_data | output | OUT_W | Signed decimated output sample |

## Verification
The embedded assertions check on every cycle that the strobe never lasts two cycles and always follows an accepted sample. They also check that the sample counter stays below the ratio, that a restart lands in CLEAR with a zero count, that the latched mode cannot move while running, and that the bypassed sixth stage stays at zero. Only the directed scenarios can show the arithmetic. These are the exact unity gain for constant inputs, the impulse response against a boxcar convolution computed in the bench, the cadence of each mode including the alias value 3, mode changes deferred until a restart, and the discard of a sample that coincides with restart.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int MAX_STAGES = 6;
    localparam int RLOG_MAX   = 6;

    // log2 of the rate reduction for a mode value
    function automatic logic [2:0] cfg_rlog(input logic [1:0] m);
        case (m)
            2'd1:    return 3'd5;
            2'd2:    return 3'd4;
            default: return 3'd6;
        endcase
    endfunction

    // number of integrator/comb stages for a mode value
    function automatic logic [2:0] cfg_stages(input logic [1:0] m);
        return (m == 2'd2) ? 3'd6 : 3'd5;
    endfunction
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
    import cic_pkg::*;
#(
    parameter int CNT_W = RLOG_MAX
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       restart,
    input  logic       in_valid,
    output logic       clr,
    output logic       run,
    output logic       dec_evt,
    output logic       six_on,
    output logic [4:0] shift_amt
);
    typedef enum logic {S_CLEAR, S_RUN} state_e;
    state_e state, state_nx;

    logic [1:0]       mode_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic [2:0]       rlog;
    logic [2:0]       nst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_CLEAR: state_nx = restart ? S_CLEAR : S_RUN;
            S_RUN:   state_nx = restart ? S_CLEAR : S_RUN;
        endcase
    end

    always_comb begin
        clr = restart || (state == S_CLEAR);
        run = (state == S_RUN) && !restart;
    end

    assign rlog      = cfg_rlog(mode_q);
    assign nst       = cfg_stages(mode_q);
    assign last      = {CNT_W{1'b1}} >> (CNT_W - int'(rlog));
    assign six_on    = (nst == 3'd6);
    assign shift_amt = 5'(int'(nst) * int'(rlog));
    assign dec_evt   = run && in_valid && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 2'd0;
            cnt    <= '0;
        end else begin
            if (state == S_CLEAR && !restart) mode_q <= mode;
            if (clr)                  cnt <= '0;
            else if (run && in_valid) cnt <= (cnt == last) ? '0 : cnt + 1'b1;
        end
    end

    assert_restart_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state == S_CLEAR) && (cnt == '0));
    assert_mode_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN) && ($past(state) == S_RUN) |-> $stable(mode_q));
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);
endmodule

// File: rtl/cic_integ_bank.sv
module cic_integ_bank
    import cic_pkg::*;
#(
    parameter int ACC_W = 46
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    six_on,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] dout
);
    logic signed [ACC_W-1:0] acc [MAX_STAGES];
    logic signed [ACC_W-1:0] sum [MAX_STAGES];

    for (genvar k = 0; k < MAX_STAGES; k++) begin : g_stage
        logic stage_on;
        assign stage_on = (k < MAX_STAGES - 1) || six_on;
        if (k == 0) begin : g_first
            assign sum[k] = acc[k] + din;
        end else begin : g_next
            assign sum[k] = acc[k] + sum[k-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                acc[k] <= '0;
            else if (clr || !stage_on) acc[k] <= '0;
            else if (en)               acc[k] <= sum[k];
        end
    end

    assign dout = six_on ? sum[MAX_STAGES-1] : sum[MAX_STAGES-2];

    assert_integ_bypass_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !six_on |-> (acc[MAX_STAGES-1] == '0));
endmodule

// File: rtl/cic_comb_bank.sv
module cic_comb_bank
    import cic_pkg::*;
#(
    parameter int ACC_W = 46
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    six_on,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] dout
);
    logic signed [ACC_W-1:0] prev [MAX_STAGES];
    logic signed [ACC_W-1:0] stin [MAX_STAGES];
    logic signed [ACC_W-1:0] diff [MAX_STAGES];

    for (genvar k = 0; k < MAX_STAGES; k++) begin : g_stage
        logic stage_on;
        assign stage_on = (k < MAX_STAGES - 1) || six_on;
        if (k == 0) begin : g_first
            assign stin[k] = din;
        end else begin : g_next
            assign stin[k] = diff[k-1];
        end
        assign diff[k] = stin[k] - prev[k];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                prev[k] <= '0;
            else if (clr || !stage_on) prev[k] <= '0;
            else if (en)               prev[k] <= stin[k];
        end
    end

    assign dout = six_on ? diff[MAX_STAGES-1] : diff[MAX_STAGES-2];

    assert_comb_bypass_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !six_on |-> (prev[MAX_STAGES-1] == '0));
endmodule

// File: rtl/cic_mode_decim.sv
module cic_mode_decim
    import cic_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16,
    parameter int GUARD = 30
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode,
    input  logic                    restart,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int ACC_W = IN_W + GUARD;

    logic                    clr, run, dec_evt, six_on;
    logic [4:0]              shift_amt;
    logic signed [ACC_W-1:0] x_ext, integ_out, comb_out, scaled;

    assign x_ext = ACC_W'(in_data);

    cic_ctrl #(.CNT_W(RLOG_MAX)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .restart(restart),
        .in_valid(in_valid), .clr(clr), .run(run), .dec_evt(dec_evt),
        .six_on(six_on), .shift_amt(shift_amt)
    );

    cic_integ_bank #(.ACC_W(ACC_W)) u_integ (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(run && in_valid),
        .six_on(six_on), .din(x_ext), .dout(integ_out)
    );

    cic_comb_bank #(.ACC_W(ACC_W)) u_comb (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(dec_evt),
        .six_on(six_on), .din(integ_out), .dout(comb_out)
    );

    assign scaled = comb_out >>> shift_amt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= dec_evt;
            if (dec_evt) out_data <= scaled[OUT_W-1:0];
        end
    end

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    assert_strobe_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid) && !$past(restart));
endmodule

// File: tb/cic_mode_decim_tb_top.sv
module cic_mode_decim_tb_top;
    localparam int CLK_P = 10;
    localparam int IN_W  = 16;
    localparam int OUT_W = 16;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [1:0]              mode = 2'd0;
    logic                    restart = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [IN_W-1:0]  in_data = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    int cap_n  = 0;
    logic signed [OUT_W-1:0] cap [0:63];
    logic last_ov;
    longint h [0:399];
    int h_len;

    always #(CLK_P/2) clk = ~clk;

    cic_mode_decim #(.IN_W(IN_W), .OUT_W(OUT_W), .GUARD(30)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .restart(restart),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic signed [IN_W-1:0] x);
        in_valid = 1'b1;
        in_data  = x;
        @(posedge clk); #1;
        in_valid = 1'b0;
        last_ov  = out_valid;
        if (out_valid && cap_n < 64) begin
            cap[cap_n] = out_data;
            cap_n++;
        end
    endtask

    task automatic idle_cycle();
        @(posedge clk); #1;
        last_ov = out_valid;
        if (out_valid && cap_n < 64) begin
            cap[cap_n] = out_data;
            cap_n++;
        end
    endtask

    task automatic restart_mode(input logic [1:0] m);
        mode = m;
        restart = 1'b1;
        @(posedge clk); #1;
        restart = 1'b0;
        @(posedge clk); #1;
        cap_n = 0;
    endtask

    function automatic int rl(input logic [1:0] m);
        return (m == 2'd1) ? 5 : (m == 2'd2) ? 4 : 6;
    endfunction
    function automatic int ns(input logic [1:0] m);
        return (m == 2'd2) ? 6 : 5;
    endfunction

    task automatic build_h(input int r, input int n);
        longint g [0:399];
        h_len = r;
        for (int i = 0; i < 400; i++) h[i] = (i < r) ? 64'sd1 : 64'sd0;
        for (int s = 1; s < n; s++) begin
            for (int i = 0; i < 400; i++) begin
                g[i] = 0;
                for (int j = 0; j < r; j++) if (i - j >= 0) g[i] += h[i-j];
            end
            for (int i = 0; i < 400; i++) h[i] = g[i];
            h_len = h_len + r - 1;
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R1 out_valid low after reset", out_valid, 0);
    endtask

    // R3: DC gain; R2/R6 cadence
    task automatic t_dc(input logic [1:0] m, input logic signed [IN_W-1:0] x);
        int r = 1 << rl(m);
        int n = ns(m);
        restart_mode(m);
        chk(out_valid == 1'b0, "R1 out_valid low after restart", out_valid, 0);
        for (int i = 0; i < r; i++) begin
            push(x);
            if (i == r - 2) chk(cap_n == 0, "R2 no output before R samples", cap_n, 0);
        end
        chk(last_ov == 1'b1, "R6 strobe after R-th sample", last_ov, 1);
        idle_cycle();
        chk(last_ov == 1'b0, "R6 strobe lasts one cycle", last_ov, 0);
        for (int i = 0; i < (n + 1) * r; i++) push(x);
        chk(cap_n == n + 2, "R2 output count for ratio", cap_n, n + 2);
        for (int k = n; k < cap_n; k++)
            chk(cap[k] == x, "R3 DC settles to input", cap[k], x);
    endtask

    // R4: impulse response against boxcar convolution
    task automatic t_impulse(input logic [1:0] m, input logic signed [IN_W-1:0] a);
        int r = 1 << rl(m);
        int n = ns(m);
        int sh = n * rl(m);
        longint e;
        build_h(r, n);
        restart_mode(m);
        push(a);
        for (int i = 1; i < (n + 1) * r; i++) push(0);
        chk(cap_n == n + 1, "R4 impulse output count", cap_n, n + 1);
        for (int k = 0; k <= n && k < cap_n; k++) begin
            e = (longint'(a) * ((k*r + r - 1 < h_len) ? h[k*r + r - 1] : 64'sd0)) >>> sh;
            chk(longint'(cap[k]) == e, "R4 impulse sample", cap[k], e);
        end
    endtask

    // R5: mode change without restart is ignored
    task automatic t_mode_lock();
        restart_mode(2'd2);
        mode = 2'd0;
        for (int i = 0; i < 16; i++) push(100);
        chk(last_ov == 1'b1, "R5 ratio kept after mode change", last_ov, 1);
        mode = 2'd2;
    endtask

    // R2: value 3 behaves as ratio 64, 5 stages
    task automatic t_mode3();
        restart_mode(2'd3);
        for (int i = 0; i < 32; i++) push(50);
        chk(cap_n == 0, "R2 mode 3 no output at 32", cap_n, 0);
        for (int i = 0; i < 32; i++) push(50);
        chk(last_ov == 1'b1, "R2 mode 3 output at 64", last_ov, 1);
    endtask

    // R6: gaps in in_valid do not advance the count
    task automatic t_gaps();
        restart_mode(2'd2);
        for (int i = 0; i < 16; i++) begin
            push(7);
            if (i == 14) chk(cap_n == 0, "R6 no output after 15 gapped samples", cap_n, 0);
            idle_cycle();
            idle_cycle();
        end
        chk(cap_n == 1, "R6 one output after 16 gapped samples", cap_n, 1);
    endtask

    // R7: sample with restart is discarded
    task automatic t_restart_drop();
        mode = 2'd2;
        in_valid = 1'b1;
        in_data = 16'sd30000;
        restart = 1'b1;
        @(posedge clk); #1;
        restart = 1'b0;
        @(posedge clk); #1;
        in_valid = 1'b0;
        cap_n = 0;
        for (int i = 0; i < 16 * 8; i++) push(0);
        chk(cap_n == 8, "R7 output count", cap_n, 8);
        for (int k = 0; k < cap_n; k++)
            chk(cap[k] == 0, "R7 discarded sample absent", cap[k], 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_dc(2'd0, 16'sd1234);
        t_dc(2'd1, -16'sd777);
        t_dc(2'd2, 16'sd20000);
        t_impulse(2'd0, 16'sd30000);
        t_impulse(2'd1, -16'sd25000);
        t_impulse(2'd2, 16'sd12345);
        t_mode_lock();
        t_mode3();
        t_gaps();
        t_restart_drop();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule